// File: doc/BRIEF.md
# Filter Coefficient Block Loader

This block sits on a chip's control bus and holds the coefficient sets for two linear-phase FIR filters, one per audio channel. Software opens a load by writing a block address. It then sends a fixed run of data words. Only the low byte of each data word is used.

Channel A takes six coefficient bytes. Channel B first takes three compatibility bytes and then six coefficient bytes. Bytes collect in a shadow buffer. The working set that the filter sees changes in one step, on the clock edge that accepts the last byte of the block. A partial block never reaches the filters.

The outputs are the two working coefficient arrays and the two 12-bit compatibility fields of channel B.

Top module: `coef_block_loader`

## Requirements
- R1: After reset, every working coefficient byte of both channels is 0x00, and both compatibility fields are 0x004.
- R2: Only bits [7:0] of a data word are stored. Bits [15:8] have no effect on any output.
- R3: An address write of 0x0001 opens a channel A block of 6 data words. The first byte lands in coefficient index 5 and the sixth in index 0. The set updates on the edge that accepts the sixth word.
- R4: An address write of 0x0005 opens a channel B block of 9 data words. Bytes b0, b1 and b2 form the 24-bit value {b2,b1,b0}. The low field is bits [11:0] and the high field is bits [23:12]. Bytes 4 to 9 fill coefficient indices 5 down to 0. All of these update on the edge that accepts the ninth word.
- R5: Before the final word of a block, no output changes. A load of one channel never changes the other channel's outputs.
- R6: A block address write in the middle of a block discards the bytes already gathered and starts counting from zero for the newly addressed channel.
- R7: An address write of any other value ends an open block with no commit.
- R8: A data word that arrives while no block is open changes nothing. It raises seqError for exactly the following cycle.
- R9: When an address write and a data write occur in the same cycle, the address write takes effect and the data word is dropped without an error.
- R10: After a block commits, no block is open until the next block address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrWr | input | 1 | Address write strobe |
| busAddr | input | 16 | Address written with addrWr |
| dataWr | input | 1 | Data word write strobe |
| busData | input | 16 | Data word; only the low byte is used |
| coefA | output | 48 | Channel A working set, byte k is coefficient k |
| coefB | output | 48 | Channel B working set, byte k is coefficient k |
| compatLo | output | 12 | Channel B compatibility field, low |
| compatHi | output | 12 | Channel B compatibility field, high |
| seqError | output | 1 | One-cycle pulse for a data word with no open block |

## Verification
The hardest situation to reach from the ports is a block that is cut short. The cut can come from a restart on either channel, from an unrelated address, or from an address write that collides with a data word. In each case the already-buffered bytes must leave no trace.

The bench builds each of these cases on purpose. It then completes a block with a computed byte pattern that differs from the abandoned bytes. This makes any leaked shadow byte show up at a known coefficient index. After every single word it also compares all outputs, so an early commit is caught.

// File: rtl/coef_load_pkg.sv
package coef_load_pkg;
  localparam int NUM_COEF     = 6;
  localparam int COMPAT_BYTES = 3;
  localparam int SEQ_MAX      = NUM_COEF + COMPAT_BYTES;
  localparam int SLOT_W       = $clog2(SEQ_MAX);
  localparam int FIELD_W      = COMPAT_BYTES * 4;
  localparam logic [FIELD_W-1:0] COMPAT_INIT = FIELD_W'(4);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_A, SEQ_B} seqState_e;

  // Strobes from control to datapath; slot numbering follows the longer
  // channel B block, channel A bytes are offset past the compat slots.
  typedef struct packed {
    logic              wr;
    logic [SLOT_W-1:0] slot;
    logic              commitA;
    logic              commitB;
  } loadStrobe_t;
endpackage

// File: rtl/coef_load_ctrl.sv
module coef_load_ctrl
  import coef_load_pkg::*;
#(
  parameter logic [15:0] ADDR_A = 16'h0001,
  parameter logic [15:0] ADDR_B = 16'h0005
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrWr,
  input  logic [15:0] busAddr,
  input  logic        dataWr,
  output loadStrobe_t stb,
  output logic        seqError
);
  localparam logic [SLOT_W-1:0] LAST_A = SLOT_W'(NUM_COEF - 1);
  localparam logic [SLOT_W-1:0] LAST_B = SLOT_W'(SEQ_MAX - 1);

  seqState_e         state;
  logic [SLOT_W-1:0] cnt;
  logic              accept;
  logic              lastByte;

  always_comb begin
    accept   = dataWr && !addrWr && (state != SEQ_IDLE);
    lastByte = (state == SEQ_A) ? (cnt == LAST_A) : (cnt == LAST_B);
    stb         = '0;
    stb.wr      = accept;
    stb.slot    = (state == SEQ_A) ? cnt + SLOT_W'(COMPAT_BYTES) : cnt;
    stb.commitA = accept && lastByte && (state == SEQ_A);
    stb.commitB = accept && lastByte && (state == SEQ_B);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      cnt      <= '0;
      seqError <= 1'b0;
    end else begin
      seqError <= dataWr && !addrWr && (state == SEQ_IDLE);
      if (addrWr) begin
        cnt <= '0;
        if (busAddr == ADDR_A)      state <= SEQ_A;
        else if (busAddr == ADDR_B) state <= SEQ_B;
        else                        state <= SEQ_IDLE;
      end else if (accept) begin
        if (lastByte) begin
          state <= SEQ_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r8_err_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> $past(dataWr && !addrWr));
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < SLOT_W'(SEQ_MAX));
  a_r10_idle_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitA || stb.commitB) |=> (state == SEQ_IDLE));
  a_r9_addr_wins: assert property (@(posedge clk) disable iff (!rstN)
    addrWr |=> (cnt == '0) && !seqError);
endmodule

// File: rtl/coef_load_dpath.sv
module coef_load_dpath
  import coef_load_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  loadStrobe_t                  stb,
  input  logic [7:0]                   byteIn,
  output logic [NUM_COEF-1:0][7:0]     coefA,
  output logic [NUM_COEF-1:0][7:0]     coefB,
  output logic [FIELD_W-1:0]           compatLo,
  output logic [FIELD_W-1:0]           compatHi
);
  logic [7:0] shadow  [SEQ_MAX-1];
  logic [7:0] fullSeq [SEQ_MAX];
  logic [COMPAT_BYTES*8-1:0] compatWord;

  genvar s;
  generate
    for (s = 0; s < SEQ_MAX - 1; s++) begin : g_shadow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                    shadow[s] <= '0;
        else if (stb.wr && stb.slot == SLOT_W'(s))    shadow[s] <= byteIn;
      end
      assign fullSeq[s] = shadow[s];
    end
    for (s = 0; s < COMPAT_BYTES; s++) begin : g_compat
      assign compatWord[s*8 +: 8] = fullSeq[s];
    end
  endgenerate
  assign fullSeq[SEQ_MAX-1] = byteIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefA    <= '0;
      coefB    <= '0;
      compatLo <= COMPAT_INIT;
      compatHi <= COMPAT_INIT;
    end else begin
      for (int k = 0; k < NUM_COEF; k++) begin
        if (stb.commitA) coefA[k] <= fullSeq[SEQ_MAX-1-k];
        if (stb.commitB) coefB[k] <= fullSeq[SEQ_MAX-1-k];
      end
      if (stb.commitB) begin
        compatLo <= compatWord[FIELD_W-1:0];
        compatHi <= compatWord[2*FIELD_W-1:FIELD_W];
      end
    end
  end

  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commitA && stb.commitB));
  a_r5_hold_a: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.commitA) |-> $stable(coefA));
  a_r5_hold_b: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.commitB) |-> $stable(coefB));
  a_r4_compat_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.commitB) |-> ($stable(compatLo) && $stable(compatHi)));
endmodule

// File: rtl/coef_block_loader.sv
module coef_block_loader
  import coef_load_pkg::*;
#(
  parameter logic [15:0] ADDR_A = 16'h0001,
  parameter logic [15:0] ADDR_B = 16'h0005
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     addrWr,
  input  logic [15:0]              busAddr,
  input  logic                     dataWr,
  input  logic [15:0]              busData,
  output logic [NUM_COEF-1:0][7:0] coefA,
  output logic [NUM_COEF-1:0][7:0] coefB,
  output logic [FIELD_W-1:0]       compatLo,
  output logic [FIELD_W-1:0]       compatHi,
  output logic                     seqError
);
  loadStrobe_t stb;

  coef_load_ctrl #(.ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrWr(addrWr), .busAddr(busAddr),
    .dataWr(dataWr), .stb(stb), .seqError(seqError)
  );

  coef_load_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIn(busData[7:0]),
    .coefA(coefA), .coefB(coefB), .compatLo(compatLo), .compatHi(compatHi)
  );
endmodule

// File: tb/tb_coef_block_loader.sv
`timescale 1ns/1ps
module tb_coef_block_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrWr = 1'b0, dataWr = 1'b0;
  logic [15:0] busAddr = '0, busData = '0;
  logic [5:0][7:0] coefA, coefB;
  logic [11:0] compatLo, compatHi;
  logic seqError;

  logic [5:0][7:0] expA = '0, expB = '0;
  logic [11:0] expLo = 12'h004, expHi = 12'h004;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  coef_block_loader dut (
    .clk(clk), .rstN(rstN), .addrWr(addrWr), .busAddr(busAddr),
    .dataWr(dataWr), .busData(busData), .coefA(coefA), .coefB(coefB),
    .compatLo(compatLo), .compatHi(compatHi), .seqError(seqError)
  );

  function automatic logic [15:0] mkWord(int seed, int i);
    return {8'(seed * 3 + i + 1), 8'(seed * 53 + i * 29 + 7)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    chk(coefA == expA, req, "coefA", 64'(coefA), 64'(expA));
    chk(coefB == expB, req, "coefB", 64'(coefB), 64'(expB));
    chk(compatLo == expLo, req, "compatLo", 64'(compatLo), 64'(expLo));
    chk(compatHi == expHi, req, "compatHi", 64'(compatHi), 64'(expHi));
  endtask

  task automatic sendAddr(logic [15:0] a);
    addrWr = 1'b1; busAddr = a;
    @(negedge clk);
    addrWr = 1'b0;
  endtask

  task automatic sendData(logic [15:0] w, bit expErr, string req);
    dataWr = 1'b1; busData = w;
    @(negedge clk);
    dataWr = 1'b0;
    chk(seqError == expErr, req, "seqError", 64'(seqError), 64'(expErr));
  endtask

  // R3 / R5: full channel A block, outputs checked after every word
  task automatic loadA(int seed);
    sendAddr(16'h0001);
    for (int i = 0; i < 6; i++) begin
      sendData(mkWord(seed, i), 1'b0, "R3");
      if (i < 5) checkAll("R5");
    end
    for (int i = 0; i < 6; i++) expA[5 - i] = mkWord(seed, i)[7:0];
    checkAll("R3");
  endtask

  // R4 / R5: full channel B block
  task automatic loadB(int seed);
    logic [23:0] comp;
    sendAddr(16'h0005);
    for (int i = 0; i < 9; i++) begin
      sendData(mkWord(seed, i), 1'b0, "R4");
      if (i < 8) checkAll("R5");
    end
    comp = {mkWord(seed, 2)[7:0], mkWord(seed, 1)[7:0], mkWord(seed, 0)[7:0]};
    expLo = comp[11:0];
    expHi = comp[23:12];
    for (int i = 3; i < 9; i++) expB[8 - i] = mkWord(seed, i)[7:0];
    checkAll("R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    chk(seqError == 1'b0, "R1", "seqError", 64'(seqError), 64'd0);

    // R8: stray word before any block, then pulse ends next cycle
    sendData(16'hFFAB, 1'b1, "R8");
    @(negedge clk);
    chk(seqError == 1'b0, "R8", "pulse width", 64'(seqError), 64'd0);
    checkAll("R8");

    // R2, R3, R4: sweep of patterns (high bytes nonzero)
    for (int seed = 0; seed < 8; seed++) begin
      loadA(seed);
      loadB(seed + 100);
    end
    // R4 with the standard compatibility bytes
    begin
      sendAddr(16'h0005);
      sendData(16'hA504, 1'b0, "R4");
      sendData(16'h5A40, 1'b0, "R4");
      sendData(16'hFF00, 1'b0, "R4");
      for (int i = 3; i < 9; i++) sendData(mkWord(7, i), 1'b0, "R4");
      expLo = 12'h004; expHi = 12'h004;
      for (int i = 3; i < 9; i++) expB[8 - i] = mkWord(7, i)[7:0];
      checkAll("R2");
    end

    // R10: block closed after commit
    sendData(16'h0011, 1'b1, "R10");
    checkAll("R10");

    // R6: partial A, restart on B; then partial A, restart on A
    sendAddr(16'h0001);
    for (int i = 0; i < 3; i++) sendData(mkWord(40, i), 1'b0, "R6");
    loadB(41);
    sendAddr(16'h0001);
    for (int i = 0; i < 4; i++) sendData(mkWord(42, i), 1'b0, "R6");
    checkAll("R6");
    loadA(43);

    // R7: other address ends the block
    sendAddr(16'h0001);
    for (int i = 0; i < 2; i++) sendData(mkWord(50, i), 1'b0, "R7");
    sendAddr(16'h0002);
    for (int i = 0; i < 4; i++) sendData(mkWord(51, i), 1'b1, "R7");
    checkAll("R7");

    // R9: collision, address wins and the data word is dropped
    sendAddr(16'h0001);
    sendData(mkWord(60, 0), 1'b0, "R9");
    addrWr = 1'b1; busAddr = 16'h0005; dataWr = 1'b1; busData = 16'h00EE;
    @(negedge clk);
    addrWr = 1'b0; dataWr = 1'b0;
    chk(seqError == 1'b0, "R9", "seqError", 64'(seqError), 64'd0);
    for (int i = 0; i < 9; i++) sendData(mkWord(61, i), 1'b0, "R9");
    begin
      logic [23:0] comp;
      comp = {mkWord(61, 2)[7:0], mkWord(61, 1)[7:0], mkWord(61, 0)[7:0]};
      expLo = comp[11:0]; expHi = comp[23:12];
      for (int i = 3; i < 9; i++) expB[8 - i] = mkWord(61, i)[7:0];
    end
    checkAll("R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule